// File: doc/BRIEF.md
# ECC Error Record Stack

This block keeps the most recent ECC error reports in a small last-in-first-out store and presents the newest one through a single 32-bit status word. An error detector pushes one record per event. Each record carries a single-error flag, a double-error flag and four per-partition single-error flags (low data word, high data word, MAC field, address field).

Software reads the status word to see the newest record. It writes a one to the valid bit (bit 31) to discard that record, which brings the next older record to the top. When the store is full, a new push evicts the oldest record and raises a sticky overflow indication. That indication stays set until reset.

Top module: `ecc_err_stack`

## Requirements
- R1: Status bit 31 reads one exactly when at least one record is stored.
- R2: A register write with bit 31 set removes the top record. The next older record then appears in the status word on the cycle after the write.
- R3: A register write with bit 31 clear changes nothing. Bits 30..0 of any write are ignored.
- R4: Status bit 0 shows the single-error flag and bit 1 the double-error flag of the top record. Bits 2, 3, 4 and 5 show the single-error flags of the low data word, high data word, MAC field and address field, in that order. The push partition input uses the same order on its bits 0..3.
- R5: Status bits 30..6 always read zero.
- R6: With the store empty, the whole status word reads zero. A pop on an empty store has no effect.
- R7: After reset the store is empty, the status word is zero and overflow is clear.
- R8: A push while DEPTH records are held drops the oldest record, keeps DEPTH records and sets overflow. Overflow then stays set until reset.
- R9: A push and an effective pop in the same cycle replace the top record with the pushed one. The record count is unchanged and overflow is not set.
- R10: Records leave in reverse order of arrival. The newest record is always the one shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push one error record this cycle |
| push_sec_i | input | 1 | Single-error flag of the pushed record |
| push_ded_i | input | 1 | Double-error flag of the pushed record |
| push_part_i | input | 4 | Partition flags: 0 low data, 1 high data, 2 MAC, 3 address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data; only bit 31 is used |
| reg_rdata_o | output | 32 | Status word showing the top record |
| overflow_o | output | 1 | Sticky flag: a record was dropped on a full push |

## Verification
The bench builds the block with the default depth of four. At that depth the full condition is reached after four pushes, so a fifth push shows the oldest-record eviction. Draining the store afterwards shows which record was lost. The same small depth lets the bench place a combined push and pop against both a full and an empty store within a few cycles.

// File: rtl/ecc_stack_pkg.sv
package ecc_stack_pkg;

    localparam int REG_W     = 32;
    localparam int VALID_BIT = 31;
    localparam int PART_N    = 4;

    typedef struct packed {
        logic [PART_N-1:0] part;  // 0 low data, 1 high data, 2 MAC, 3 address
        logic              ded;
        logic              sec;
    } err_rec_t;

    localparam int REC_W = $bits(err_rec_t);

endpackage

// File: rtl/ecc_stack_store.sv
module ecc_stack_store
    import ecc_stack_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         push_i,
    input  err_rec_t                     push_rec_i,
    input  logic                         pop_i,
    output err_rec_t                     top_rec_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic                         overflow_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        err_rec_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]     cnt;
        logic                 ovf;
    } store_t;

    store_t st_d, st_q;

    logic             pop_ok;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign pop_ok  = pop_i && (st_q.cnt != '0);
    assign top_idx = IDX_W'(st_q.cnt - 1'b1);
    assign wr_idx  = IDX_W'(st_q.cnt);

    always_comb begin
        st_d = st_q;
        if (push_i && pop_ok) begin
            st_d.ent[top_idx] = push_rec_i;
        end else if (push_i) begin
            if (st_q.cnt == FULL) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    st_d.ent[i] = st_q.ent[i+1];
                end
                st_d.ent[DEPTH-1] = push_rec_i;
                st_d.ovf          = 1'b1;
            end else begin
                st_d.ent[wr_idx] = push_rec_i;
                st_d.cnt         = st_q.cnt + 1'b1;
            end
        end else if (pop_ok) begin
            st_d.ent[top_idx] = '0;
            st_d.cnt          = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_rec_o  = (st_q.cnt != '0) ? st_q.ent[top_idx] : '0;
    assign level_o    = st_q.cnt;
    assign overflow_o = st_q.ovf;

endmodule

// File: rtl/ecc_stack_regif.sv
module ecc_stack_regif
    import ecc_stack_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic [CNT_W-1:0]  level_i,
    input  err_rec_t          top_rec_i,
    output logic              pop_o,
    output logic [REG_W-1:0]  rdata_o
);

    logic valid;

    assign pop_o = reg_wr_i && reg_wdata_i[VALID_BIT];
    assign valid = (level_i != '0);

    always_comb begin
        rdata_o = '0;
        rdata_o[VALID_BIT] = valid;
        if (valid) begin
            rdata_o[REC_W-1:0] = top_rec_i;
        end
    end

endmodule

// File: rtl/ecc_err_stack.sv
module ecc_err_stack
    import ecc_stack_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic              push_sec_i,
    input  logic              push_ded_i,
    input  logic [3:0]        push_part_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              overflow_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    err_rec_t         push_rec;
    err_rec_t         top_rec;
    logic             pop;
    logic [CNT_W-1:0] level;

    assign push_rec = '{part: push_part_i, ded: push_ded_i, sec: push_sec_i};

    ecc_stack_store #(.DEPTH(DEPTH)) u_store (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_i     (push_i),
        .push_rec_i (push_rec),
        .pop_i      (pop),
        .top_rec_o  (top_rec),
        .level_o    (level),
        .overflow_o (overflow_o)
    );

    ecc_stack_regif #(.CNT_W(CNT_W)) u_regif (
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .level_i     (level),
        .top_rec_i   (top_rec),
        .pop_o       (pop),
        .rdata_o     (reg_rdata_o)
    );

endmodule

// File: rtl/ecc_stack_chk.sv
module ecc_stack_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       push_i,
    input logic                       reg_wr_i,
    input logic [31:0]                reg_wdata_i,
    input logic [31:0]                reg_rdata_i,
    input logic                       overflow_i,
    input logic [$clog2(DEPTH+1)-1:0] level_i
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic pop_req;
    assign pop_req = reg_wr_i && reg_wdata_i[31];

    // R1
    a_r1_valid_tracks_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_i[31] == (level_i != '0));

    // R2
    a_r2_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_req && !push_i && level_i != '0) |=> (level_i == CNT_W'($past(level_i) - 1'b1)));

    // R3
    a_r3_zero_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !reg_wdata_i[31] && !push_i) |=> $stable(reg_rdata_i) && $stable(level_i));

    // R5
    a_r5_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_i[30:6] == '0);

    // R6
    a_r6_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_i == '0) |-> (reg_rdata_i == '0));

    // R8
    a_r8_full_push_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_req && level_i == FULL) |=> overflow_i && (level_i == FULL));

    // R8
    a_r8_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_i |=> overflow_i);

    // R9
    a_r9_swap_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_req && level_i != '0) |=> $stable(level_i) && (overflow_i == $past(overflow_i)));

endmodule

bind ecc_err_stack ecc_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_i (reg_rdata_o),
    .overflow_i  (overflow_o),
    .level_i     (level)
);

// File: tb/test_ecc_err_stack.sv
module test_ecc_err_stack;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        push_i = 1'b0;
    logic        push_sec_i = 1'b0;
    logic        push_ded_i = 1'b0;
    logic [3:0]  push_part_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        overflow_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk_i = ~clk_i;  // 50 MHz

    ecc_err_stack #(.DEPTH(4)) i_ecc_err_stack (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push_i),
        .push_sec_i  (push_sec_i),
        .push_ded_i  (push_ded_i),
        .push_part_i (push_part_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .overflow_o  (overflow_o)
    );

    typedef struct packed {
        logic        push;
        logic [5:0]  rec;   // {part[3:0], ded, sec} as in status bits 5..0
        logic        wr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        ovf;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'h05, 1'b0, 32'h0,        32'h8000_0005, 1'b0},
        '{1'b1, 6'h21, 1'b0, 32'h0,        32'h8000_0021, 1'b0},
        '{1'b0, 6'h00, 1'b1, 32'h7FFF_FFFF, 32'h8000_0021, 1'b0},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h8000_0005, 1'b0},
        '{1'b1, 6'h02, 1'b0, 32'h0,        32'h8000_0002, 1'b0},
        '{1'b1, 6'h19, 1'b1, 32'h8000_0000, 32'h8000_0019, 1'b0},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h8000_0005, 1'b0},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h0000_0000, 1'b0},
        '{1'b0, 6'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
        '{1'b1, 6'h0D, 1'b0, 32'h0,        32'h8000_000D, 1'b0},
        '{1'b1, 6'h02, 1'b0, 32'h0,        32'h8000_0002, 1'b0},
        '{1'b1, 6'h21, 1'b0, 32'h0,        32'h8000_0021, 1'b0},
        '{1'b1, 6'h11, 1'b0, 32'h0,        32'h8000_0011, 1'b0},
        '{1'b1, 6'h09, 1'b0, 32'h0,        32'h8000_0009, 1'b1},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h8000_0011, 1'b1},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h8000_0021, 1'b1},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h8000_0002, 1'b1},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h0000_0000, 1'b1},
        '{1'b1, 6'h03, 1'b1, 32'h8000_0000, 32'h8000_0003, 1'b1},
        '{1'b0, 6'h00, 1'b1, 32'h8000_0000, 32'h0000_0000, 1'b1}
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1:   return "R4";
            2:      return "R3";
            3, 6:   return "R2";
            4:      return "R10";
            5:      return "R9";
            7:      return "R1";
            8:      return "R6";
            13:     return "R8";
            14, 15, 16, 17: return "R10";
            18:     return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic p, logic [5:0] rec, logic w, logic [31:0] wd);
        push_i      = p;
        push_part_i = rec[5:2];
        push_ded_i  = rec[1];
        push_sec_i  = rec[0];
        reg_wr_i    = w;
        reg_wdata_i = wd;
        @(negedge clk_i);
        push_i   = 1'b0;
        reg_wr_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R7: state under and right after reset
        check("R7", reg_rdata_o, 32'h0);
        check("R7", {31'h0, overflow_o}, 32'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R7", reg_rdata_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].push, VEC[i].rec, VEC[i].wr, VEC[i].wd);
            check(vec_req(i), reg_rdata_o, VEC[i].exp);
            check("R8", {31'h0, overflow_o}, {31'h0, VEC[i].ovf});
        end

        // R7: reset clears the sticky overflow and empties the store
        step(1'b1, 6'h05, 1'b0, 32'h0);
        rst_ni = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R7", reg_rdata_o, 32'h0);
        check("R7", {31'h0, overflow_o}, 32'h0);

        // R9: swap on a full store does not overflow
        for (int k = 1; k <= 4; k++) step(1'b1, 6'(k), 1'b0, 32'h0);
        step(1'b1, 6'h3F, 1'b1, 32'h8000_0000);
        check("R9", reg_rdata_o, 32'h8000_003F);
        check("R9", {31'h0, overflow_o}, 32'h0);
        // R5: reserved bits stay zero even with all fields set
        check("R5", {1'b0, reg_rdata_o[30:6], 6'h0}, 32'h0);
        // R10: swapped top leaves, then earlier ones in reverse order
        step(1'b0, 6'h0, 1'b1, 32'h8000_0000);
        check("R10", reg_rdata_o, 32'h8000_0003);
        step(1'b0, 6'h0, 1'b1, 32'h8000_0000);
        check("R10", reg_rdata_o, 32'h8000_0002);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule